// File: doc/BRIEF.md
# PS/2 Host Interface Register Block

This block sits between a word-wide register bus and a byte-level keyboard or mouse link. Software sees five registers: a control word, a status word, a data port, a clock-divisor word and an interrupt-identification word. Received bytes land in a one-entry holding register with a pending flag. A read of the data port collects the held byte. A write to the data port hands a command byte to the device side.

Both device-side directions use a valid/ready handshake. The receive side refuses new bytes while one is still unread, so an unread byte is never overwritten. A single interrupt output combines the pending flag, gated by one control bit, with a second control bit that forces the interrupt on. The divisor word is only stored and read back. It does not change any timing.

Top module: `ps2_host_regs`

## Requirements
- R1: After a synchronous active-low reset, the control and divisor words are 0, no byte is pending, `irq` is 0, `tx_valid` is 0, `rx_ready` is 1 and a data-port read returns 0.
- R2: Writes to byte offset 0x000 (control) and 0x00C (divisor) store the low 8 bits of `req_wdata`. Reads at those offsets return the stored value with all upper bits zero.
- R3: `irq` equals (pending AND control bit 4) OR control bit 3. It takes its new value in the cycle after the control write that changes it.
- R4: A read at offset 0x004 (status) returns 0x10 while a byte is pending and 0 otherwise.
- R5: A read at offset 0x010 (interrupt identification) returns the pending flag in bit 0 with bit 1 always 1, giving 0x3 or 0x2.
- R6: `rx_ready` is 1 exactly while no byte is pending. A byte offered while `rx_ready` is 0 is not taken, and the held byte and pending flag do not change.
- R7: A data-port read (offset 0x008) while a byte is pending returns that byte and clears the pending flag. Without a pending byte it returns the byte most recently read.
- R8: A data-port write while no command is waiting presents the low 8 bits of `req_wdata` on `tx_data` with `tx_valid` high until a cycle with `tx_ready` high. A data-port write made while a command is waiting is dropped.
- R9: Reads in the window 0xFE0 to 0xFFC, and at any other unmapped offset, return 0. Writes to the status and interrupt-identification offsets change no register.
- R10: Every read request returns its data on `rd_data` with `rd_valid` high in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 12 | Byte offset of the access |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | 32 | Read data |
| rx_valid | input | 1 | Device side offers a received byte |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Block can take a received byte |
| tx_valid | output | 1 | Command byte waiting for the device |
| tx_data | output | 8 | Command byte |
| tx_ready | input | 1 | Device takes the command byte |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the device side honours the handshakes. It offers bytes only through `rx_valid` and `rx_data`, and it never expects a byte to be taken while `rx_ready` is low. They also assume that each bus request lasts exactly one cycle. The stimulus drives every request for a single clock and returns `req_valid` low between accesses. It offers received bytes for one cycle at a time, including some deliberately offered while a byte is still pending. It holds `tx_ready` low while checking that a waiting command stays put.

// File: rtl/ps2h_pkg.sv
// Package: shared selector type and register offsets for the PS/2 host
// register block. Assumes a 12-bit byte offset on the register bus.
package ps2h_pkg;

    localparam int unsigned OFS_W = 12;

    localparam logic [OFS_W-1:0] OFS_CTRL = 12'h000;
    localparam logic [OFS_W-1:0] OFS_STAT = 12'h004;
    localparam logic [OFS_W-1:0] OFS_DATA = 12'h008;
    localparam logic [OFS_W-1:0] OFS_DIV  = 12'h00C;
    localparam logic [OFS_W-1:0] OFS_IID  = 12'h010;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_STAT,
        SEL_DATA,
        SEL_DIV,
        SEL_IID,
        SEL_IDWIN
    } reg_sel_e;

endpackage

// File: rtl/ps2h_decode.sv
// Module: ps2h_decode
// Maps a byte offset to a register selector. The low two address bits are
// ignored (word access). The top 32 bytes of the space form a read-as-zero
// window. Purely combinational.
module ps2h_decode
    import ps2h_pkg::*;
#(
    parameter int unsigned ADDR_W = OFS_W
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);

    localparam int unsigned WORD_W = ADDR_W - 2;
    localparam int unsigned WIN_W  = ADDR_W - 5;

    logic [WORD_W-1:0] word;
    assign word = addr[ADDR_W-1:2];

    // purpose: translate the word index to a register selector
    always_comb begin
        sel = SEL_NONE;
        if (addr[ADDR_W-1:5] == {WIN_W{1'b1}})
            sel = SEL_IDWIN;
        else if (word == WORD_W'(OFS_CTRL >> 2))
            sel = SEL_CTRL;
        else if (word == WORD_W'(OFS_STAT >> 2))
            sel = SEL_STAT;
        else if (word == WORD_W'(OFS_DATA >> 2))
            sel = SEL_DATA;
        else if (word == WORD_W'(OFS_DIV >> 2))
            sel = SEL_DIV;
        else if (word == WORD_W'(OFS_IID >> 2))
            sel = SEL_IID;
    end

endmodule

// File: rtl/ps2h_rx_hold.sv
// Module: ps2h_rx_hold
// One-entry receive holding register with a pending flag. It takes a byte
// only while empty (ready is low while pending). A pop clears pending. The
// held byte stays after the pop, so it doubles as "last byte read".
module ps2h_rx_hold #(
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    output logic              rx_ready,
    input  logic              pop,
    output logic              pending,
    output logic [BYTE_W-1:0] held_byte
);

    logic take;

    assign rx_ready = !pending;
    assign take     = rx_valid && rx_ready;

    // purpose: capture an offered byte and track the pending flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending   <= 1'b0;
            held_byte <= '0;
        end else begin
            if (take)
                held_byte <= rx_data;
            pending <= take || (pending && !pop);
        end
    end

    // R6: an unread byte is neither lost nor overwritten
    a_r6_hold_unread: assert property (@(posedge clk) disable iff (!rst_n)
        pending && !pop |=> pending && $stable(held_byte));

    // R7: popping a pending byte empties the holder
    a_r7_pop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        pending && pop |=> !pending);

endmodule

// File: rtl/ps2h_tx_slot.sv
// Module: ps2h_tx_slot
// One-entry command slot toward the device. A load is taken only while
// the slot is empty. The byte is held with valid high until ready.
module ps2h_tx_slot #(
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_byte,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data,
    input  logic              tx_ready
);

    // purpose: fill on an accepted load, empty on a device handshake
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_valid <= 1'b0;
            tx_data  <= '0;
        end else if (!tx_valid) begin
            if (load) begin
                tx_valid <= 1'b1;
                tx_data  <= load_byte;
            end
        end else if (tx_ready) begin
            tx_valid <= 1'b0;
        end
    end

    // R8: a waiting command keeps its byte until the device takes it
    a_r8_cmd_held: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

endmodule

// File: rtl/ps2h_cfg_regs.sv
// Module: ps2h_cfg_regs
// Software-written control and clock-divisor words. The divisor is only
// stored. Write strobes arrive already decoded.
module ps2h_cfg_regs #(
    parameter int unsigned CTRL_W = 8,
    parameter int unsigned DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic              div_we,
    input  logic [DIV_W-1:0]  div_wdata,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic [DIV_W-1:0]  div_q
);

    // purpose: hold the control word
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (ctrl_we)
            ctrl_q <= ctrl_wdata;
    end

    // purpose: hold the clock-divisor word
    always_ff @(posedge clk) begin
        if (!rst_n)
            div_q <= '0;
        else if (div_we)
            div_q <= div_wdata;
    end

endmodule

// File: rtl/ps2_host_regs.sv
// Module: ps2_host_regs (top)
// Register front end of a PS/2 keyboard/mouse host. Assumes single-cycle
// bus requests. Read data is registered and returned one cycle later. The
// interrupt combines the pending flag gated by one control bit with a
// second control bit that forces the interrupt on.
module ps2_host_regs
    import ps2h_pkg::*;
#(
    parameter int unsigned DATA_W       = 32,
    parameter int unsigned ADDR_W       = OFS_W,
    parameter int unsigned BYTE_W       = 8,
    parameter int unsigned CTRL_W       = 8,
    parameter int unsigned DIV_W        = 8,
    parameter int unsigned RX_IE_BIT    = 4,
    parameter int unsigned TX_FORCE_BIT = 3,
    parameter int unsigned PEND_BIT     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data,
    input  logic              tx_ready,
    output logic              irq
);

    localparam logic [DATA_W-1:0] STAT_PEND = DATA_W'(1) << PEND_BIT;
    localparam logic [DATA_W-1:0] IID_TXRDY = DATA_W'(2);

    reg_sel_e          sel;
    logic              rd_req;
    logic              wr_req;
    logic              pending;
    logic [BYTE_W-1:0] held_byte;
    logic [CTRL_W-1:0] ctrl_q;
    logic [DIV_W-1:0]  div_q;
    logic [DATA_W-1:0] rd_mux;

    assign rd_req = req_valid && !req_write;
    assign wr_req = req_valid && req_write;

    ps2h_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr (req_addr),
        .sel  (sel)
    );

    ps2h_cfg_regs #(.CTRL_W(CTRL_W), .DIV_W(DIV_W)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_we    (wr_req && sel == SEL_CTRL),
        .ctrl_wdata (req_wdata[CTRL_W-1:0]),
        .div_we     (wr_req && sel == SEL_DIV),
        .div_wdata  (req_wdata[DIV_W-1:0]),
        .ctrl_q     (ctrl_q),
        .div_q      (div_q)
    );

    ps2h_rx_hold #(.BYTE_W(BYTE_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .rx_ready  (rx_ready),
        .pop       (rd_req && sel == SEL_DATA),
        .pending   (pending),
        .held_byte (held_byte)
    );

    ps2h_tx_slot #(.BYTE_W(BYTE_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (wr_req && sel == SEL_DATA),
        .load_byte (req_wdata[BYTE_W-1:0]),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data),
        .tx_ready  (tx_ready)
    );

    // purpose: select the read value for the addressed register
    always_comb begin
        case (sel)
            SEL_CTRL: rd_mux = DATA_W'(ctrl_q);
            SEL_STAT: rd_mux = pending ? STAT_PEND : '0;
            SEL_DATA: rd_mux = DATA_W'(held_byte);
            SEL_DIV:  rd_mux = DATA_W'(div_q);
            SEL_IID:  rd_mux = IID_TXRDY | DATA_W'(pending);
            default:  rd_mux = '0;
        endcase
    end

    // purpose: register the read response one cycle after the request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_req;
            if (rd_req)
                rd_data <= rd_mux;
        end
    end

    // purpose: combine gated receive interrupt with forced transmit interrupt
    assign irq = (pending && ctrl_q[RX_IE_BIT]) || ctrl_q[TX_FORCE_BIT];

    // R10: a read request is answered in the next cycle
    a_r10_rd_next: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_valid);

    // R3: a control write with the force bit set raises irq next cycle
    a_r3_force_irq: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req && sel == SEL_CTRL && req_wdata[TX_FORCE_BIT] |=> irq);

    // R4: status read while pending returns the pending code
    a_r4_stat_pend: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && sel == SEL_STAT && pending |=> rd_data == STAT_PEND);

    // R9: reads in the identification window return zero
    a_r9_idwin_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && sel == SEL_IDWIN |=> rd_data == '0);

endmodule

// File: tb/test_ps2_host_regs.sv
module test_ps2_host_regs;

    typedef struct packed {
        logic        wr;
        logic [11:0] addr;
        logic [31:0] wdata;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    // Register-only vectors; no byte is pending while these run.
    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 12'h000, 32'h0000_0105, 32'h0, 8'd2},  // R2 ctrl write
        '{1'b0, 12'h000, 32'h0, 32'h0000_0005, 8'd2},  // R2 ctrl read, upper cut
        '{1'b1, 12'h00C, 32'h1234_56A7, 32'h0, 8'd2},  // R2 div write
        '{1'b0, 12'h00C, 32'h0, 32'h0000_00A7, 8'd2},  // R2 div read
        '{1'b0, 12'h004, 32'h0, 32'h0000_0000, 8'd4},  // R4 status idle
        '{1'b0, 12'h010, 32'h0, 32'h0000_0002, 8'd5},  // R5 iid idle
        '{1'b0, 12'h008, 32'h0, 32'h0000_0000, 8'd7},  // R7 data, none yet
        '{1'b1, 12'h004, 32'hFFFF_FFFF, 32'h0, 8'd9},  // R9 status write
        '{1'b1, 12'h010, 32'hFFFF_FFFF, 32'h0, 8'd9},  // R9 iid write
        '{1'b0, 12'h000, 32'h0, 32'h0000_0005, 8'd9},  // R9 ctrl unchanged
        '{1'b0, 12'h00C, 32'h0, 32'h0000_00A7, 8'd9},  // R9 div unchanged
        '{1'b0, 12'hFE0, 32'h0, 32'h0000_0000, 8'd9},  // R9 window low
        '{1'b0, 12'hFFC, 32'h0, 32'h0000_0000, 8'd9},  // R9 window high
        '{1'b0, 12'h014, 32'h0, 32'h0000_0000, 8'd9}   // R9 unmapped
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_ready;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        tx_ready = 1'b0;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    ps2_host_regs i_ps2_host_regs (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R10 rd_valid", {31'b0, rd_valid}, 32'h1);
        d = rd_data;
    endtask

    task automatic rx_push(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 tx_valid", {31'b0, tx_valid}, 32'h0);
        chk("R1 rx_ready", {31'b0, rx_ready}, 32'h1);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].wr) begin
                bus_write(VECS[i].addr, VECS[i].wdata);
            end else begin
                bus_read(VECS[i].addr, v);
                chk($sformatf("R%0d vector %0d", VECS[i].req, i), v, VECS[i].exp);
            end
        end

        // R6 receive path: take a byte, ready drops
        rx_push(8'h5A);
        chk("R6 rx_ready low while pending", {31'b0, rx_ready}, 32'h0);
        chk("R3 irq gated off (ctrl=0x05)", {31'b0, irq}, 32'h0);
        bus_read(12'h004, v);
        chk("R4 status pending", v, 32'h10);
        bus_read(12'h010, v);
        chk("R5 iid pending", v, 32'h3);
        bus_write(12'h000, 32'h10);
        chk("R3 irq enabled with pending", {31'b0, irq}, 32'h1);
        rx_push(8'h77);                 // R6 offered while pending: refused
        bus_read(12'h008, v);
        chk("R7 pop returns held byte", v, 32'h5A);
        chk("R3 irq drops after pop", {31'b0, irq}, 32'h0);
        chk("R6 rx_ready back high", {31'b0, rx_ready}, 32'h1);
        bus_read(12'h004, v);
        chk("R4 status idle after pop", v, 32'h0);
        bus_read(12'h008, v);
        chk("R7 repeat read returns last byte", v, 32'h5A);
        rx_push(8'h33);
        bus_read(12'h008, v);
        chk("R7 next byte", v, 32'h33);

        // R3 force bit
        bus_write(12'h000, 32'h08);
        chk("R3 forced irq", {31'b0, irq}, 32'h1);
        bus_write(12'h000, 32'h00);
        chk("R3 irq cleared", {31'b0, irq}, 32'h0);

        // R8 command path
        bus_write(12'h008, 32'h0000_01C5);
        chk("R8 tx_valid", {31'b0, tx_valid}, 32'h1);
        chk("R8 tx_data", {24'b0, tx_data}, 32'hC5);
        bus_write(12'h008, 32'h99);
        chk("R8 busy write dropped", {24'b0, tx_data}, 32'hC5);
        @(negedge clk) tx_ready = 1'b1;
        @(negedge clk) tx_ready = 1'b0;
        chk("R8 slot empties on handshake", {31'b0, tx_valid}, 32'h0);
        bus_write(12'h008, 32'h99);
        chk("R8 next command", {24'b0, tx_data}, 32'h99);
        @(negedge clk) tx_ready = 1'b1;
        @(negedge clk) tx_ready = 1'b0;

        // R1 reset in the middle of activity
        rx_push(8'hAB);
        bus_write(12'h000, 32'h18);
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        chk("R1 irq after reset", {31'b0, irq}, 32'h0);
        chk("R1 rx_ready after reset", {31'b0, rx_ready}, 32'h1);
        bus_read(12'h000, v);
        chk("R1 ctrl after reset", v, 32'h0);
        bus_read(12'h008, v);
        chk("R1 data after reset", v, 32'h0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule